// File: doc/BRIEF.md
# Binary to Three-Digit BCD Store

This block turns an unsigned binary value into decimal digits and writes each digit to a byte-wide memory write port. A one-cycle `start` pulse accepts the value and a base address. The block then finds the hundreds, tens and ones digits by serial repeated subtraction of the weights 100, 10 and 1. It writes the hundreds digit at the base address, the tens digit at the next address and the ones digit at the one after that. A one-cycle `done` pulse closes the operation.

The block works on a private copy of the value and holds its own copy of the base address, so the caller's inputs are free once the operation has been accepted. By default each digit is counted in a local register and written once. A parameter selects another write policy: that variant writes a zero to the digit location first and then writes the updated count after every successful subtraction. The width, digit-count and write-policy parameters are checked at elaboration.

Top module: `bcd3_store`

## Requirements
- R1: When `start` is sampled high while idle, the block writes exactly three bytes, in this order: the hundreds digit at `base_idx`, the tens digit at `base_idx`+1 and the ones digit at `base_idx`+2. Addresses wrap modulo 2^16.
- R2: Each written byte holds a decimal digit from 0 to 9, zero-extended to 8 bits.
- R3: Every digit count starts again from zero, for every digit and for every operation. Nothing carries over from an earlier digit or an earlier operation.
- R4: An input of 255 writes the digits 2, 5, 5. An input of 0 writes three zero bytes.
- R5: `done` is high for exactly one cycle. That cycle immediately follows the cycle of the third write, and no write happens while `done` is high.
- R6: Let S be the sum of the three digits and t0 the rising edge that samples `start`. `done` is high in the cycle that begins S+4 rising edges after t0. This gives a worst case of 23 edges, reached for the input 199.
- R7: `start` has no effect from the edge that accepts an operation up to the edge that raises `done`. It produces no extra writes and no change to the digits being written.
- R8: Changing `bin_val` or `base_idx` after acceptance has no effect on the written addresses or data.
- R9: During and right after reset, `wr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion when the block is idle |
| bin_val | input | 8 | Binary value to convert |
| base_idx | input | 16 | Address for the hundreds digit |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 8 | Memory write data (one digit) |
| wr_en | output | 1 | Memory write enable, one cycle per byte |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The checker tracks operations from the `start` pulses it observes. It therefore assumes that `start` is only raised as a pulse, and that any `start` during an operation is one the design must ignore. The checker latches `base_idx` at acceptance to bound the write addresses, so it takes the accepting `start` cycle to carry the intended base. The stimulus drives every input on falling edges and holds the accepting values stable over the sampling edge. It disturbs the value and the base only after acceptance, together with a second `start` pulse, so that the checker's own record of each operation stays correct.

// File: rtl/bcd3_pkg.sv
package bcd3_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CLR  = 2'd1,
      ST_RUN  = 2'd2,
      ST_FIN  = 2'd3
   } bcd3_state_e;

   // 10 raised to n, computed rather than tabulated
   function automatic int unsigned pow10(input int n);
      int unsigned acc;
      acc = 1;
      for (int i = 0; i < n; i++) acc = acc * 10;
      return acc;
   endfunction

endpackage

// File: rtl/bcd3_weight_sel.sv
module bcd3_weight_sel #(
   parameter int VAL_W  = 8,
   parameter int DIGITS = 3,
   parameter int IDX_W  = 2
) (
   input  logic [IDX_W-1:0] idx,
   output logic [VAL_W-1:0] weight
);
   localparam int SLOTS = 1 << IDX_W;

   logic [VAL_W-1:0] tbl [SLOTS];

   // digit 0 is the most significant one
   for (genvar k = 0; k < SLOTS; k++) begin : g_wt
      if (k < DIGITS) begin : g_used
         assign tbl[k] = VAL_W'(bcd3_pkg::pow10(DIGITS - 1 - k));
      end else begin : g_spare
         assign tbl[k] = VAL_W'(1);
      end
   end

   assign weight = tbl[idx];
endmodule

// File: rtl/bcd3_sub_step.sv
module bcd3_sub_step #(
   parameter int VAL_W = 8
) (
   input  logic [VAL_W-1:0] work,
   input  logic [VAL_W-1:0] weight,
   output logic             fits,
   output logic [VAL_W-1:0] work_next
);
   assign fits      = (work >= weight);
   assign work_next = work - weight;
endmodule

// File: rtl/bcd3_ctrl.sv
module bcd3_ctrl #(
   parameter int VAL_W       = 8,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int DIGITS      = 3,
   parameter int INCR_WRITES = 0,
   parameter int IDX_W       = 2,
   parameter int CNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VAL_W-1:0]  bin_val,
   input  logic [ADDR_W-1:0] base_idx,
   input  logic              fits,
   input  logic [VAL_W-1:0]  work_next,
   output logic [VAL_W-1:0]  work_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_en,
   output logic              done
);
   import bcd3_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

   bcd3_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_inc;
   logic [ADDR_W-1:0] digit_addr;

   // write policy: once per digit on the miss, or on every hit plus a clear
   logic wr_on_hit, wr_on_miss, use_clear;
   if (INCR_WRITES != 0) begin : g_incr
      assign wr_on_hit  = 1'b1;
      assign wr_on_miss = 1'b0;
      assign use_clear  = 1'b1;
   end else begin : g_once
      assign wr_on_hit  = 1'b0;
      assign wr_on_miss = 1'b1;
      assign use_clear  = 1'b0;
   end

   assign cnt_inc    = cnt_q + CNT_W'(1);
   assign digit_addr = base_q + ADDR_W'(idx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         work_q  <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         base_q  <= '0;
         wr_addr <= '0;
         wr_data <= '0;
         wr_en   <= 1'b0;
         done    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         done  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  work_q  <= bin_val;
                  base_q  <= base_idx;
                  idx_q   <= '0;
                  cnt_q   <= '0;
                  state_q <= use_clear ? ST_CLR : ST_RUN;
               end
            end
            ST_CLR: begin
               wr_en   <= 1'b1;
               wr_addr <= digit_addr;
               wr_data <= '0;
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (fits) begin
                  work_q <= work_next;
                  cnt_q  <= cnt_inc;
                  if (wr_on_hit) begin
                     wr_en   <= 1'b1;
                     wr_addr <= digit_addr;
                     wr_data <= DATA_W'(cnt_inc);
                  end
               end else begin
                  if (wr_on_miss) begin
                     wr_en   <= 1'b1;
                     wr_addr <= digit_addr;
                     wr_data <= DATA_W'(cnt_q);
                  end
                  cnt_q <= '0;
                  if (idx_q == LAST_IDX) begin
                     state_q <= ST_FIN;
                  end else begin
                     idx_q   <= idx_q + IDX_W'(1);
                     state_q <= use_clear ? ST_CLR : ST_RUN;
                  end
               end
            end
            ST_FIN: begin
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bcd3_store.sv
module bcd3_store #(
   parameter int VAL_W       = 8,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int DIGITS      = 3,
   parameter int INCR_WRITES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VAL_W-1:0]  bin_val,
   input  logic [ADDR_W-1:0] base_idx,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_en,
   output logic              done
);
   localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
   localparam int CNT_W = 4;

   // elaboration-time parameter checks
   if (VAL_W < 1 || VAL_W > 30) begin : g_chk_vw
      $error("bcd3_store: VAL_W out of range");
   end
   if (bcd3_pkg::pow10(DIGITS) <= (2 ** VAL_W) - 1) begin : g_chk_dig_lo
      $error("bcd3_store: DIGITS too small for VAL_W");
   end
   if (bcd3_pkg::pow10(DIGITS - 1) > (2 ** VAL_W) - 1) begin : g_chk_dig_hi
      $error("bcd3_store: DIGITS too large for VAL_W");
   end
   if (DATA_W < CNT_W) begin : g_chk_dw
      $error("bcd3_store: DATA_W must hold a digit");
   end
   if (INCR_WRITES != 0 && INCR_WRITES != 1) begin : g_chk_mode
      $error("bcd3_store: INCR_WRITES must be 0 or 1");
   end

   logic [VAL_W-1:0] work_q, work_next, weight;
   logic [IDX_W-1:0] idx_q;
   logic             fits;

   bcd3_weight_sel #(.VAL_W(VAL_W), .DIGITS(DIGITS), .IDX_W(IDX_W)) u_wsel (
      .idx    (idx_q),
      .weight (weight)
   );

   bcd3_sub_step #(.VAL_W(VAL_W)) u_sub (
      .work      (work_q),
      .weight    (weight),
      .fits      (fits),
      .work_next (work_next)
   );

   bcd3_ctrl #(
      .VAL_W(VAL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIGITS(DIGITS),
      .INCR_WRITES(INCR_WRITES), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bin_val   (bin_val),
      .base_idx  (base_idx),
      .fits      (fits),
      .work_next (work_next),
      .work_q    (work_q),
      .idx_q     (idx_q),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_en     (wr_en),
      .done      (done)
   );
endmodule

// File: rtl/bcd3_store_chk.sv
module bcd3_store_chk #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int DIGITS      = 3,
   parameter int INCR_WRITES = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] base_idx,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_en,
   input logic              done
);
   localparam int LAT_MAX = 9 * DIGITS + 2 * DIGITS + 4;

   logic              busy_c;
   logic [ADDR_W-1:0] base_l;
   logic [15:0]       lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c  <= 1'b0;
         base_l  <= '0;
         lat_cnt <= '0;
      end else if (start && (!busy_c || done)) begin
         busy_c  <= 1'b1;
         base_l  <= base_idx;
         lat_cnt <= '0;
      end else if (done) begin
         busy_c <= 1'b0;
      end else if (busy_c) begin
         lat_cnt <= lat_cnt + 16'd1;
      end
   end

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

   p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && INCR_WRITES == 0) |-> $past(wr_en));

   p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_data <= DATA_W'(9)));

   p_addr_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (busy_c && (ADDR_W'(wr_addr - base_l) < ADDR_W'(DIGITS))));

   p_latency_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_c |-> (lat_cnt <= 16'(LAT_MAX)));

   p_done_in_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_c);
endmodule

bind bcd3_store bcd3_store_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIGITS(DIGITS), .INCR_WRITES(INCR_WRITES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .base_idx (base_idx),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .wr_en    (wr_en),
   .done     (done)
);

// File: tb/bcd3_store_bench.sv
module bcd3_store_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  bin_val = '0;
   logic [15:0] base_idx = '0;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic        wr_en;
   logic        done;

   int compared = 0;
   int mismatched = 0;
   logic [23:0] exp_q[$];
   logic prev_we = 1'b0;
   logic prev_done = 1'b0;
   int   writes_in_op = 0;
   logic mon_on = 1'b0;

   always #5 clk = ~clk;

   bcd3_store u_bcd3_store (
      .clk(clk), .rst_n(rst_n), .start(start), .bin_val(bin_val),
      .base_idx(base_idx), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_en(wr_en), .done(done)
   );

   // monitor: pops expected writes and checks done timing
   always @(negedge clk) begin
      if (mon_on) begin
         if (wr_en) begin
            compared++;
            if (exp_q.size() == 0) begin
               mismatched++;
               $display("FAIL R7/R8: unexpected write addr=%h data=%h expected none", wr_addr, wr_data);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               if ({wr_addr, wr_data} !== e) begin
                  mismatched++;
                  $display("FAIL R1/R3: write addr=%h data=%h expected addr=%h data=%h",
                           wr_addr, wr_data, e[23:8], e[7:0]);
               end
            end
            writes_in_op++;
         end
         if (done) begin
            compared++;
            if (!prev_we || wr_en || prev_done || writes_in_op != 3) begin
               mismatched++;
               $display("FAIL R5: done prev_we=%0b we=%0b prev_done=%0b writes=%0d expected 1 0 0 3",
                        prev_we, wr_en, prev_done, writes_in_op);
            end
            writes_in_op = 0;
         end
      end
      prev_we   = wr_en;
      prev_done = done;
   end

   task automatic run_op(input logic [7:0] v, input logic [15:0] b, input bit disturb);
      int h, t, o, s, cycles;
      bit got;
      h = v / 100; t = (v / 10) % 10; o = v % 10; s = h + t + o;
      exp_q.push_back({b, 8'(h)});
      exp_q.push_back({b + 16'd1, 8'(t)});
      exp_q.push_back({b + 16'd2, 8'(o)});
      @(negedge clk);
      start = 1'b1; bin_val = v; base_idx = b;
      cycles = 0; got = 0;
      while (!got && cycles < 60) begin
         @(negedge clk);
         cycles++;
         if (cycles == 1) start = 1'b0;
         if (disturb && cycles == 3) begin
            start = 1'b1; bin_val = ~v; base_idx = b ^ 16'h5555; // R7 R8
         end
         if (disturb && cycles == 4) start = 1'b0;
         if (done) got = 1;
      end
      compared++;
      if (!got || cycles != s + 5) begin
         mismatched++;
         $display("FAIL R6: value %0d done after %0d cycles expected %0d", v, cycles, s + 5);
      end
      repeat (3) @(negedge clk);
      compared++;
      if (exp_q.size() != 0) begin
         mismatched++;
         $display("FAIL R1: %0d writes missing expected 0", exp_q.size());
         exp_q.delete();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compared++;
      if (wr_en !== 1'b0 || done !== 1'b0) begin
         mismatched++;
         $display("FAIL R9: reset we=%b done=%b expected 0 0", wr_en, done);
      end
      rst_n = 1'b1;
      @(negedge clk);
      compared++;
      if (wr_en !== 1'b0 || done !== 1'b0) begin
         mismatched++;
         $display("FAIL R9: after reset we=%b done=%b expected 0 0", wr_en, done);
      end
      mon_on = 1'b1;
      run_op(8'd255, 16'h0300, 0);   // R4
      run_op(8'd0,   16'h1000, 0);   // R4 R3
      run_op(8'd199, 16'hFFFE, 0);   // R1 wrap, R6 worst case
      run_op(8'd100, 16'h0020, 0);   // R2
      run_op(8'd9,   16'h0040, 0);
      run_op(8'd10,  16'h0050, 0);
      run_op(8'd99,  16'h0060, 0);
      run_op(8'd128, 16'h2222, 1);   // R7 R8
      run_op(8'd42,  16'h7FFF, 1);   // R7 R8
      run_op(8'd7,   16'h0000, 0);   // R3 after larger values
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule